// File: doc/BRIEF.md
# Speculative Counter Pad Unit

In counter-mode memory encryption each line is decrypted with a pad. The pad is the keyed cipher applied to the line address and the line's sequence number. Normally the sequence number has to come back from memory before the pad can be computed, so the cipher pipeline sits idle during the fetch. This unit makes use of that idle time. When a line miss is accepted, it feeds a burst of guessed sequence numbers into the pipelined pad generator, one block per cycle. The guesses start at the page root value and count upward. Each finished pad lands in a small table.

When the fetched sequence number and ciphertext arrive, a bank of parallel comparators checks the number against every guess. On a hit, the stored pads for the matching guess are XORed with the ciphertext. On a miss, the unit stops guessing and sends the real sequence number through the pipeline. It then waits for those pads. Either way, the unit emits the plaintext once, with a flag saying whether speculation succeeded.

The cipher is a keyed stub with a parameterised stage count, so its result can be computed exactly. Only one miss may be outstanding at a time.

Top module: `ctr_pad_spec`

## Requirements
- R1: After reset, miss_ready_o is 1 and out_valid_o is 0.
- R2: For line half h, the cipher input is 128 bits: a 64-bit address in the upper bits, then a 64-bit sequence number in the lower bits. The address is (miss_vaddr_i + 16*h) mod 2^ADDR_W, zero-extended to 64 bits.
- R3: The pad is computed from input x over rounds s = 0..STAGES-1. Each round sets x to (x rotated left by 7) XOR (key_i + s + 1), with 128-bit addition. The generator accepts one block per cycle.
- R4: The guesses for a miss are root+k for k = 0..DEPTH-1, taken mod 2^64. If fill_seq_i equals one of them, out_hit_o is 1 and out_data_o is the ciphertext XOR the pads of that guess.
- R5: If no guess matches, out_hit_o is 0 and out_data_o is the ciphertext XOR the pads computed from fill_seq_i itself.
- R6: Each 128-bit half of the line, half h at bits [128h+127:128h] of fill_data_i and out_data_o, uses its own pad built from its own address.
- R7: A sequence number may arrive before its pad leaves the pipeline. In that case the output waits, and out_valid_o never rises fewer than STAGES+1 cycles after the miss was accepted.
- R8: A miss is accepted when miss_valid_i and miss_ready_o are both 1. miss_ready_o then stays 0 until the cycle out_valid_o is 1. miss_valid_i is ignored while miss_ready_o is 0.
- R9: fill_valid_i is ignored while no miss is outstanding, and also once a fill has been taken for the current miss.
- R10: out_valid_o is a single-cycle pulse, and miss_ready_o is 1 in that same cycle.
- R11: A pad still in flight from an earlier miss never takes part in a later result. This includes a back-to-back hit on the first guess.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | 128 | Cipher key, held stable |
| miss_valid_i | input | 1 | Line miss request |
| miss_ready_o | output | 1 | Unit idle, can take a miss |
| miss_vaddr_i | input | ADDR_W | Line virtual address |
| miss_root_i | input | 64 | Page root sequence number |
| fill_valid_i | input | 1 | Fetched sequence number and data present |
| fill_seq_i | input | 64 | Fetched sequence number |
| fill_data_i | input | 128*HALVES | Encrypted line |
| out_valid_o | output | 1 | Plaintext valid pulse |
| out_hit_o | output | 1 | 1 when a guessed pad was used |
| out_data_o | output | 128*HALVES | Decrypted line |

## Verification
The checker enforces several properties on every cycle:
- the request/ready protocol and the single-cycle output pulse;
- the rule that results only ever follow a busy period;
- a lower bound on latency measured from acceptance, which catches outputs that skip the pipeline wait;
- uniqueness of the guess comparator match.

The remaining properties can only be shown by bench scenarios:
- whether the plaintext and hit flag are correct;
- the half addressing and the zero padding;
- sequence numbers that wrap around;
- fills that arrive while idle or a second time;
- stale pads from a preceding back-to-back request.

// File: rtl/ctr_pad_pkg.sv
package ctr_pad_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned SEQ_W = 64;
  localparam int unsigned VA_W  = 64;

  function automatic logic [BLK_W-1:0] pad_round(input logic [BLK_W-1:0] x,
                                                 input logic [BLK_W-1:0] key,
                                                 input int unsigned      s);
    logic [BLK_W-1:0] rk;
    rk = key + BLK_W'(s + 1);
    return {x[BLK_W-8:0], x[BLK_W-1 -: 7]} ^ rk;
  endfunction
endpackage

// File: rtl/pad_cipher_stub.sv
module pad_cipher_stub
  import ctr_pad_pkg::*;
#(
  parameter int unsigned STAGES = 6,
  parameter int unsigned TAG_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BLK_W-1:0] key_i,
  input  logic             in_valid_i,
  input  logic [BLK_W-1:0] in_blk_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  output logic [BLK_W-1:0] out_blk_o,
  output logic [TAG_W-1:0] out_tag_o
);
  logic [STAGES-1:0] vld_q;
  logic [BLK_W-1:0]  dat_q [STAGES];
  logic [TAG_W-1:0]  tag_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else begin
      vld_q[0] <= in_valid_i;
      for (int s = 1; s < STAGES; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk_i) begin
    dat_q[0] <= pad_round(in_blk_i, key_i, 0);
    tag_q[0] <= in_tag_i;
    for (int s = 1; s < STAGES; s++) begin
      dat_q[s] <= pad_round(dat_q[s-1], key_i, s);
      tag_q[s] <= tag_q[s-1];
    end
  end

  assign out_valid_o = vld_q[STAGES-1];
  assign out_blk_o   = dat_q[STAGES-1];
  assign out_tag_o   = tag_q[STAGES-1];
endmodule

// File: rtl/guess_match.sv
module guess_match
  import ctr_pad_pkg::*;
#(
  parameter int unsigned DEPTH = 5
) (
  input  logic [SEQ_W-1:0] root_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic [DEPTH-1:0] match_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    logic [SEQ_W-1:0] guess;
    assign guess      = root_i + SEQ_W'(k);
    assign match_o[k] = (guess == seq_i);
  end
endmodule

// File: rtl/pad_table.sv
module pad_table
  import ctr_pad_pkg::*;
#(
  parameter int unsigned NENT   = 6,
  parameter int unsigned HALVES = 2,
  localparam int unsigned ENT_W  = $clog2(NENT),
  localparam int unsigned HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    wr_en_i,
  input  logic [ENT_W-1:0]        wr_entry_i,
  input  logic [HALF_W-1:0]       wr_half_i,
  input  logic [BLK_W-1:0]        wr_pad_i,
  input  logic [ENT_W-1:0]        rd_entry_i,
  output logic [HALVES*BLK_W-1:0] rd_pads_o,
  output logic                    rd_full_o
);
  logic [HALVES*BLK_W-1:0] pad_arr [NENT];
  logic [HALVES-1:0]       vld_arr [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic [HALVES-1:0][BLK_W-1:0] pad_q;
    logic [HALVES-1:0]            vld_q;
    logic                         hit_w;
    assign hit_w = wr_en_i && (wr_entry_i == ENT_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q <= '0;
      else if (clear_i) vld_q <= '0;
      else if (hit_w)   vld_q[wr_half_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (hit_w) pad_q[wr_half_i] <= wr_pad_i;
    end

    assign pad_arr[e] = pad_q;
    assign vld_arr[e] = vld_q;
  end

  assign rd_pads_o = pad_arr[rd_entry_i];
  assign rd_full_o = &vld_arr[rd_entry_i];
endmodule

// File: rtl/ctr_pad_spec.sv
module ctr_pad_spec
  import ctr_pad_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned HALVES = 2,
  parameter int unsigned STAGES = 6,
  localparam int unsigned LINE_W = HALVES * BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BLK_W-1:0]  key_i,
  input  logic              miss_valid_i,
  output logic              miss_ready_o,
  input  logic [ADDR_W-1:0] miss_vaddr_i,
  input  logic [SEQ_W-1:0]  miss_root_i,
  input  logic              fill_valid_i,
  input  logic [SEQ_W-1:0]  fill_seq_i,
  input  logic [LINE_W-1:0] fill_data_i,
  output logic              out_valid_o,
  output logic              out_hit_o,
  output logic [LINE_W-1:0] out_data_o
);
  localparam int unsigned NENT   = DEPTH + 1;
  localparam int unsigned ENT_W  = $clog2(NENT);
  localparam int unsigned HALF_W = (HALVES > 1) ? $clog2(HALVES) : 1;
  localparam int unsigned HCNT_W = $clog2(HALVES + 1);
  localparam int unsigned TAG_W  = 1 + ENT_W + HALF_W;

  logic              busy_q, have_fill_q, epoch_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [SEQ_W-1:0]  root_q, fseq_q;
  logic [LINE_W-1:0] ct_q;
  logic [ENT_W-1:0]  g_cnt_q;
  logic [HALF_W-1:0] g_half_q;
  logic [HCNT_W-1:0] r_cnt_q;

  logic [DEPTH-1:0]  match_vec;
  logic              hit;
  logic [ENT_W-1:0]  hit_idx, sel_entry;
  logic              accept, fill_take, real_mode, spec_go, real_go, done;
  logic [HALF_W-1:0] iss_half;
  logic [SEQ_W-1:0]  iss_seq;
  logic [ENT_W-1:0]  iss_entry;
  logic [ADDR_W-1:0] iss_addr;
  logic [BLK_W-1:0]  iss_blk;
  logic              pipe_vld;
  logic [BLK_W-1:0]  pipe_blk;
  logic [TAG_W-1:0]  pipe_tag;
  logic              tbl_wr;
  logic [LINE_W-1:0] rd_pads;
  logic              rd_full;

  guess_match #(.DEPTH(DEPTH)) u_match (
    .root_i (root_q),
    .seq_i  (fseq_q),
    .match_o(match_vec)
  );

  always_comb begin
    hit_idx = '0;
    for (int k = 0; k < DEPTH; k++) if (match_vec[k]) hit_idx = ENT_W'(k);
  end
  assign hit = |match_vec;

  assign accept    = miss_valid_i && !busy_q;
  assign fill_take = fill_valid_i && busy_q && !have_fill_q;
  assign real_mode = have_fill_q && !hit;
  assign spec_go   = busy_q && !real_mode && (g_cnt_q < ENT_W'(DEPTH));
  assign real_go   = busy_q && real_mode && (r_cnt_q < HCNT_W'(HALVES));
  assign sel_entry = real_mode ? ENT_W'(DEPTH) : hit_idx;
  assign done      = busy_q && have_fill_q && rd_full;

  // issue mux: guesses first, real number only after a mismatch
  always_comb begin
    if (real_mode) begin
      iss_half  = HALF_W'(r_cnt_q);
      iss_seq   = fseq_q;
      iss_entry = ENT_W'(DEPTH);
    end else begin
      iss_half  = g_half_q;
      iss_seq   = root_q + SEQ_W'(g_cnt_q);
      iss_entry = g_cnt_q;
    end
    iss_addr = vaddr_q + (ADDR_W'(iss_half) << 4);
    iss_blk  = {VA_W'(iss_addr), iss_seq};
  end

  pad_cipher_stub #(.STAGES(STAGES), .TAG_W(TAG_W)) u_cipher (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_i      (key_i),
    .in_valid_i (spec_go || real_go),
    .in_blk_i   (iss_blk),
    .in_tag_i   ({epoch_q, iss_entry, iss_half}),
    .out_valid_o(pipe_vld),
    .out_blk_o  (pipe_blk),
    .out_tag_o  (pipe_tag)
  );

  // drop pads tagged with a finished request
  assign tbl_wr = pipe_vld && busy_q && (pipe_tag[TAG_W-1] == epoch_q);

  pad_table #(.NENT(NENT), .HALVES(HALVES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .wr_en_i   (tbl_wr),
    .wr_entry_i(pipe_tag[TAG_W-2 -: ENT_W]),
    .wr_half_i (pipe_tag[HALF_W-1:0]),
    .wr_pad_i  (pipe_blk),
    .rd_entry_i(sel_entry),
    .rd_pads_o (rd_pads),
    .rd_full_o (rd_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      have_fill_q <= 1'b0;
      epoch_q     <= 1'b0;
      g_cnt_q     <= '0;
      g_half_q    <= '0;
      r_cnt_q     <= '0;
      out_valid_o <= 1'b0;
      out_hit_o   <= 1'b0;
    end else begin
      out_valid_o <= done;
      if (accept) begin
        busy_q      <= 1'b1;
        have_fill_q <= 1'b0;
        g_cnt_q     <= '0;
        g_half_q    <= '0;
        r_cnt_q     <= '0;
      end else if (done) begin
        busy_q    <= 1'b0;
        epoch_q   <= ~epoch_q;
        out_hit_o <= !real_mode;
      end else begin
        if (fill_take) have_fill_q <= 1'b1;
        if (spec_go) begin
          if (g_half_q == HALF_W'(HALVES - 1)) begin
            g_half_q <= '0;
            g_cnt_q  <= g_cnt_q + 1'b1;
          end else begin
            g_half_q <= g_half_q + 1'b1;
          end
        end
        if (real_go) r_cnt_q <= r_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept) begin
      vaddr_q <= miss_vaddr_i;
      root_q  <= miss_root_i;
    end
    if (fill_take) begin
      fseq_q <= fill_seq_i;
      ct_q   <= fill_data_i;
    end
    if (done) out_data_o <= ct_q ^ rd_pads;
  end

  assign miss_ready_o = !busy_q;
endmodule

// File: rtl/ctr_pad_spec_chk.sv
module ctr_pad_spec_chk #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned STAGES = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             miss_valid_i,
  input logic             miss_ready_o,
  input logic             out_valid_o,
  input logic [DEPTH-1:0] match_vec
);
  logic [31:0] since_acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_acc_q <= '0;
    else if (miss_valid_i && miss_ready_o) since_acc_q <= '0;
    else if (since_acc_q != 32'hFFFF_FFFF) since_acc_q <= since_acc_q + 1'b1;
  end

  assert_single_outstanding_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> !miss_ready_o);

  assert_busy_before_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$past(miss_ready_o));

  assert_result_frees_unit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> miss_ready_o);

  assert_result_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  assert_pad_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (since_acc_q >= 32'(STAGES + 1)));

  assert_unique_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
endmodule

bind ctr_pad_spec ctr_pad_spec_chk #(.DEPTH(DEPTH), .STAGES(STAGES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .miss_valid_i(miss_valid_i),
  .miss_ready_o(miss_ready_o),
  .out_valid_o (out_valid_o),
  .match_vec   (match_vec)
);

// File: tb/sim_ctr_pad_spec.sv
module sim_ctr_pad_spec;
  localparam int ADDR_W = 48;
  localparam int DEPTH  = 5;
  localparam int HALVES = 2;
  localparam int STAGES = 6;
  localparam int LINE_W = HALVES * 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [127:0]      key;
  logic              miss_valid = 1'b0;
  logic              miss_ready;
  logic [ADDR_W-1:0] miss_vaddr = '0;
  logic [63:0]       miss_root = '0;
  logic              fill_valid = 1'b0;
  logic [63:0]       fill_seq = '0;
  logic [LINE_W-1:0] fill_data = '0;
  logic              out_valid, out_hit;
  logic [LINE_W-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  ctr_pad_spec #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .HALVES(HALVES), .STAGES(STAGES)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_vaddr_i(miss_vaddr), .miss_root_i(miss_root),
    .fill_valid_i(fill_valid), .fill_seq_i(fill_seq), .fill_data_i(fill_data),
    .out_valid_o(out_valid), .out_hit_o(out_hit), .out_data_o(out_data)
  );

  function automatic logic [127:0] ref_pad(input logic [ADDR_W-1:0] va, input int h,
                                           input logic [63:0] seq, input logic [127:0] k);
    logic [ADDR_W-1:0] a;
    logic [127:0] x;
    a = va + ADDR_W'(16 * h);
    x = {64'(a), seq};
    for (int s = 0; s < STAGES; s++) x = {x[120:0], x[127:121]} ^ (k + 128'(s + 1));
    return x;
  endfunction

  function automatic logic [LINE_W-1:0] ref_line(input logic [ADDR_W-1:0] va, input logic [63:0] seq,
                                                 input logic [LINE_W-1:0] ct, input logic [127:0] k);
    logic [LINE_W-1:0] r;
    for (int h = 0; h < HALVES; h++) r[h*128 +: 128] = ct[h*128 +: 128] ^ ref_pad(va, h, seq, k);
    return r;
  endfunction

  task automatic check(input string req, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // poke: drive a second miss while busy; dbl: drive a second fill after the first
  task automatic run_req(input string req, input logic [ADDR_W-1:0] va, input logic [63:0] root,
                         input logic [63:0] seq, input logic [LINE_W-1:0] ct, input int dly,
                         input bit poke, input bit dbl);
    logic [63:0] diff;
    logic exp_hit;
    logic [63:0] used_seq;
    int n;
    while (!miss_ready) @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va; miss_root = root;
    @(negedge clk);
    miss_valid = 1'b0;
    if (poke) begin
      check({req, " R8 busy"}, LINE_W'(miss_ready), LINE_W'(0));
      miss_valid = 1'b1; miss_vaddr = ~va; miss_root = ~root;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    for (int i = 0; i < dly; i++) @(negedge clk);
    fill_valid = 1'b1; fill_seq = seq; fill_data = ct;
    @(negedge clk);
    fill_valid = 1'b0;
    if (dbl) begin
      fill_valid = 1'b1; fill_seq = seq + 64'd1; fill_data = ~ct;
      @(negedge clk);
      fill_valid = 1'b0;
    end
    n = 0;
    while (!out_valid && n < 2000) begin @(negedge clk); n++; end
    diff = seq - root;
    exp_hit = (diff < 64'(DEPTH));
    used_seq = exp_hit ? root + diff : seq;
    check({req, " R4/R5/R6 data"}, out_data, ref_line(va, used_seq, ct, key));
    check({req, " R4/R5 hit"}, LINE_W'(out_hit), LINE_W'(exp_hit));
    check({req, " R10 ready"}, LINE_W'(miss_ready), LINE_W'(1));
    @(negedge clk);
    check({req, " R10 pulse"}, LINE_W'(out_valid), LINE_W'(0));
  endtask

  function automatic logic [LINE_W-1:0] rnd_line();
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LINE_W / 32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    void'($urandom(32'h5eed_c0de));
    key = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    check("R1 ready at reset", LINE_W'(miss_ready), LINE_W'(1));
    check("R1 no output at reset", LINE_W'(out_valid), LINE_W'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R9: fill while idle is ignored
    fill_valid = 1'b1; fill_seq = 64'hDEAD; fill_data = '1;
    @(negedge clk);
    fill_valid = 1'b0;
    check("R9 idle fill no output", LINE_W'(out_valid), LINE_W'(0));
    @(negedge clk);

    // R7: fill arrives before the first pad leaves the pipeline
    run_req("R7 early guess0", 48'h1234_5678_9AC0, 64'h0123_4567_89AB_CDEF,
            64'h0123_4567_89AB_CDEF, rnd_line(), 0, 1'b0, 1'b0);
    run_req("R4 last guess late", 48'h0000_0000_1000, 64'hAAAA_0000_0000_0010,
            64'hAAAA_0000_0000_0010 + 64'(DEPTH - 1), rnd_line(), 20, 1'b0, 1'b0);
    run_req("R5 just past depth", 48'h0000_0000_2000, 64'h77, 64'h77 + 64'(DEPTH), rnd_line(), 3, 1'b0, 1'b0);
    run_req("R5 below root", 48'h0000_0000_3000, 64'h100, 64'hFF, rnd_line(), 2, 1'b0, 1'b0);
    run_req("R4 wrap", 48'h0000_0000_4000, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, rnd_line(), 4, 1'b0, 1'b0);
    run_req("R2 addr wrap pad", 48'hFFFF_FFFF_FFF0, 64'h55, 64'h56, rnd_line(), 1, 1'b0, 1'b0);
    run_req("R8 busy miss ignored", 48'h0000_0000_5000, 64'h900, 64'h902, rnd_line(), 5, 1'b1, 1'b0);
    run_req("R9 second fill ignored", 48'h0000_0000_6000, 64'h333, 64'h333, rnd_line(), 0, 1'b0, 1'b1);
    run_req("R9 second fill miss", 48'h0000_0000_6100, 64'h333, 64'h999, rnd_line(), 7, 1'b0, 1'b1);
    // R11: back-to-back hits on guess 0 while later guesses are still in flight
    for (int i = 0; i < 4; i++)
      run_req("R11 back-to-back", 48'(64'h7000 + 64'(i * 32)), 64'(i * 1000), 64'(i * 1000),
              rnd_line(), 0, 1'b0, 1'b0);

    for (int i = 0; i < 60; i++) begin
      logic [63:0] root;
      logic [63:0] seq;
      logic [ADDR_W-1:0] va;
      root = {$urandom, $urandom};
      va = {$urandom, $urandom};
      va[4:0] = '0;
      seq = ($urandom_range(0, 9) == 0) ? {$urandom, $urandom} : root + 64'($urandom_range(0, 7));
      run_req("R3 random", va, root, seq, rnd_line(), $urandom_range(0, 12),
              1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0));
    end
    finish_run();
  end
endmodule